// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer controlled through one 8-bit control/status byte on a simple byte-wide register bus. Once armed, it counts clock cycles toward a timeout. The timeout length is a base period, given in cycles, doubled once per step of a 4-bit prescaler field. Software keeps the watchdog quiet by pulsing a kick input, or by writing the register, before the count runs out. Either action restarts the count from zero.

Two enables select what a timeout does:

- **Interrupt only:** the timeout raises an interrupt flag.
- **Reset only:** the timeout asks for a one-cycle system reset.
- **Both enables:** the first timeout raises the interrupt. If software acknowledges it, the interrupt enable and the flag are cleared and the watchdog drops to reset-only mode. If no acknowledge arrives, the next timeout requests the reset.

A timed change-enable bit guards the reset enable and the prescaler, so that a stray write cannot silently weaken the watchdog. An external reset-flag input pins the reset enable on while it is high.

The mode is held by a small state machine with six states:

- `WD_OFF`: stopped.
- `WD_IRQ`: interrupt only.
- `WD_RST`: reset only.
- `WD_DUAL`: both enables, no flag yet.
- `WD_DUAL_ARMED`: both enables, flag already set.
- `WD_BITE`: a one-cycle state that drives the reset request.

Transitions:

- **Mode follow:** every cycle the state moves to the mode decoded from the register's next value.
- **Arm:** a timeout in `WD_DUAL` sets the flag. The next value then decodes to `WD_DUAL_ARMED`.
- **Relax:** an acknowledge in `WD_DUAL_ARMED` clears the flag and the interrupt enable. The next value then decodes to `WD_RST`.
- **Bite:** a timeout in `WD_RST` or `WD_DUAL_ARMED` enters `WD_BITE`.
- **Release:** `WD_BITE` always leaves after one cycle, through mode follow.

Top module: `wdog_guarded`

## Requirements
- R1: The register reads as {flag[7], irq_enable[6], prescaler[3] at bit 5, change_enable[4], reset_enable[3], prescaler[2:0] at bits 2..0}. After reset it reads 0x00 and both `irq` and `sys_rst_req` are low.
- R2: While irq_enable and reset_enable are both 0, no interrupt and no reset request is ever produced.
- R3: A timeout occurs exactly BASE_CYCLES << p cycles after the clock edge that captured the last write or kick, where p is the prescaler value. Any prescaler value above PRESC_CAP (9) is treated as PRESC_CAP.
- R4: With only irq_enable set, a timeout sets bit 7 and drives `irq` high (`irq` = flag AND irq_enable). No reset request is made.
- R5: With only reset_enable set, a timeout drives `sys_rst_req` high for exactly one cycle. The count restarts at that timeout, so the requests repeat every period.
- R6: With both enables set, the first timeout sets the flag and `irq`. An `irq_ack` while `irq` is high clears bits 7 and 6, and the next timeout then gives a reset request. Without an acknowledge, the timeout after the first gives the reset request.
- R7: Writing 1 to bit 7 clears the flag and writing 0 leaves it unchanged. In interrupt-only mode, `irq_ack` clears the flag but keeps irq_enable.
- R8: A write with bit 4 at 0 cannot clear reset_enable or change the prescaler. A write with bit 4 at 1 can do both. Setting reset_enable is always possible.
- R9: Bit 4 reads 1 for exactly GUARD_CYCLES (4) cycles after the write that set it, then reads 0.
- R10: While `wdt_flag_in` is high, bit 3 reads 1 and clearing it by a write is ignored. The stored bit stays 1 after the input falls.
- R11: A `kick` pulse restarts the count from zero, as does any register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| kick | input | 1 | Restarts the timeout count |
| wdt_flag_in | input | 1 | External watchdog-reset flag; forces the reset enable on |
| irq_ack | input | 1 | Interrupt taken by the CPU |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The timeout function is run from a vector table with patterns that differ in:

- **Enable combination:** stopped, interrupt only, reset only, both.
- **Prescaler value:** zero, small values, the cap, and values above the cap.

Each vector measures the cycle of the first event and which output fired. This separates a wrong shift amount or a missing clamp from a wrong mode decode. Directed sequences then cover the dual mode with and without an acknowledge, flag clearing by write and by acknowledge, and guarded against unguarded writes. They also cover change-enable expiry, the forced reset enable, and a kick part-way through a count.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    // Bit positions in the control/status byte
    localparam int FLAG_POS = 7;
    localparam int IE_POS   = 6;
    localparam int PHI_POS  = 5;   // prescaler bit 3
    localparam int CE_POS   = 4;
    localparam int RE_POS   = 3;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       ce;
        logic       re;
        logic [3:0] presc;
    } wd_ctrl_t;

    typedef enum logic [2:0] {
        WD_OFF,
        WD_IRQ,
        WD_RST,
        WD_DUAL,
        WD_DUAL_ARMED,
        WD_BITE
    } wd_state_e;

    function automatic wd_state_e mode_of(input wd_ctrl_t c);
        wd_state_e m;
        unique case ({c.ie, c.re})
            2'b00:   m = WD_OFF;
            2'b10:   m = WD_IRQ;
            2'b01:   m = WD_RST;
            default: m = c.flag ? WD_DUAL_ARMED : WD_DUAL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wdog_csr.sv
`timescale 1ns/1ps
module wdog_csr
    import wdog_pkg::*;
#(
    parameter int GUARD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wdt_flag_in,
    input  logic       irq_ack,
    input  logic       set_flag,
    output wd_ctrl_t   ctrl_q,
    output wd_ctrl_t   ctrl_d,
    output logic [7:0] rd_data
);

    localparam int GW = (GUARD_CYCLES > 2) ? $clog2(GUARD_CYCLES) : 1;

    logic [GW-1:0] g_cnt_q, g_cnt_d;
    logic [3:0]    wr_presc;
    logic          ack_eff;

    assign wr_presc = {wr_data[PHI_POS], wr_data[2:0]};
    assign ack_eff  = irq_ack & ctrl_q.flag & ctrl_q.ie;

    always_comb begin
        ctrl_d  = ctrl_q;
        g_cnt_d = g_cnt_q;

        // interrupt flag: a timeout sets it; an acknowledge or a written one clears it
        if (set_flag) begin
            ctrl_d.flag = 1'b1;
        end else if (ack_eff || (wr_en && wr_data[FLAG_POS])) begin
            ctrl_d.flag = 1'b0;
        end

        // interrupt enable: free to write; an acknowledge in dual mode drops it
        if (wr_en) begin
            ctrl_d.ie = wr_data[IE_POS];
        end else if (ack_eff && ctrl_q.re) begin
            ctrl_d.ie = 1'b0;
        end

        // reset enable: setting is free, clearing needs the change bit in the same write
        if (wr_en) begin
            ctrl_d.re = wr_data[RE_POS] | (ctrl_q.re & ~wr_data[CE_POS]);
        end
        if (wdt_flag_in) begin
            ctrl_d.re = 1'b1;
        end

        // prescaler: guarded like the reset enable
        if (wr_en && wr_data[CE_POS]) begin
            ctrl_d.presc = wr_presc;
        end

        // change-enable window
        if (wr_en) begin
            ctrl_d.ce = wr_data[CE_POS];
            g_cnt_d   = '0;
        end else if (ctrl_q.ce) begin
            if (g_cnt_q == GW'(GUARD_CYCLES - 1)) begin
                ctrl_d.ce = 1'b0;
                g_cnt_d   = '0;
            end else begin
                g_cnt_d = g_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            g_cnt_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            g_cnt_q <= g_cnt_d;
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[FLAG_POS] = ctrl_q.flag;
        rd_data[IE_POS]   = ctrl_q.ie;
        rd_data[PHI_POS]  = ctrl_q.presc[3];
        rd_data[CE_POS]   = ctrl_q.ce;
        rd_data[RE_POS]   = ctrl_q.re | wdt_flag_in;
        rd_data[2:0]      = ctrl_q.presc[2:0];
    end

endmodule

// File: rtl/wdog_period.sv
`timescale 1ns/1ps
module wdog_period #(
    parameter int BASE_CYCLES = 16,
    parameter int PRESC_CAP   = 9,
    parameter int CW          = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] presc,
    output logic       tmo
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic [3:0]    presc_eff;

    assign presc_eff = (presc > 4'(PRESC_CAP)) ? 4'(PRESC_CAP) : presc;
    assign lim_m1    = (CW'(BASE_CYCLES) << presc_eff) - CW'(1);
    assign tmo       = run & ~restart & (cnt_q == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart || tmo) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
`timescale 1ns/1ps
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tmo,
    input  wd_ctrl_t ctrl_q,
    input  wd_ctrl_t ctrl_d,
    output logic     set_flag,
    output logic     irq,
    output logic     sys_rst_req
);

    wd_state_e state_q, state_d;
    logic      bite;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // timeout action and next state
    always_comb begin
        set_flag = 1'b0;
        bite     = 1'b0;
        unique case (state_q)
            WD_IRQ, WD_DUAL:       set_flag = tmo;
            WD_RST, WD_DUAL_ARMED: bite     = tmo;
            WD_OFF, WD_BITE:       ;
            default:               ;
        endcase
        state_d = bite ? WD_BITE : mode_of(ctrl_d);
    end

    // outputs
    always_comb begin
        sys_rst_req = (state_q == WD_BITE);
        irq         = ctrl_q.flag & ctrl_q.ie;
    end

endmodule

// File: rtl/wdog_guarded.sv
`timescale 1ns/1ps
module wdog_guarded
    import wdog_pkg::*;
#(
    parameter int BASE_CYCLES  = 16,
    parameter int PRESC_CAP    = 9,
    parameter int GUARD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       kick,
    input  logic       wdt_flag_in,
    input  logic       irq_ack,
    output logic       irq,
    output logic       sys_rst_req
);

    localparam int CW = $clog2(BASE_CYCLES) + PRESC_CAP + 1;

    wd_ctrl_t ctrl_q, ctrl_d;
    logic     set_flag;
    logic     tmo;

    wdog_csr #(
        .GUARD_CYCLES(GUARD_CYCLES)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wdt_flag_in(wdt_flag_in),
        .irq_ack    (irq_ack),
        .set_flag   (set_flag),
        .ctrl_q     (ctrl_q),
        .ctrl_d     (ctrl_d),
        .rd_data    (rd_data)
    );

    wdog_period #(
        .BASE_CYCLES(BASE_CYCLES),
        .PRESC_CAP  (PRESC_CAP),
        .CW         (CW)
    ) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.ie | ctrl_q.re),
        .restart(wr_en | kick),
        .presc  (ctrl_q.presc),
        .tmo    (tmo)
    );

    wdog_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmo        (tmo),
        .ctrl_q     (ctrl_q),
        .ctrl_d     (ctrl_d),
        .set_flag   (set_flag),
        .irq        (irq),
        .sys_rst_req(sys_rst_req)
    );

endmodule

// File: rtl/wdog_guarded_chk.sv
`timescale 1ns/1ps
module wdog_guarded_chk #(
    parameter int GUARD_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       wdt_flag_in,
    input logic       irq,
    input logic       sys_rst_req
);

    logic [7:0] ce_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_run <= '0;
        end else if (wr_en) begin
            ce_run <= wr_data[4] ? 8'd1 : 8'd0;
        end else if (rd_data[4]) begin
            ce_run <= ce_run + 8'd1;
        end else begin
            ce_run <= '0;
        end
    end

    // R2
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[6] && !rd_data[3]) |=> !sys_rst_req);

    // R5
    bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R4
    flag_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[7]) |-> $past(rd_data[6]));

    // R8
    presc_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable({rd_data[5], rd_data[2:0]}));

    // R9
    guard_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> (ce_run <= 8'(GUARD_CYCLES)));

    // R10
    force_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_flag_in |=> rd_data[3]);

    wire unused_irq = irq;

endmodule

bind wdog_guarded wdog_guarded_chk #(
    .GUARD_CYCLES(GUARD_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .wdt_flag_in(wdt_flag_in),
    .irq        (irq),
    .sys_rst_req(sys_rst_req)
);

// File: tb/wdog_guarded_bench.sv
`timescale 1ns/1ps
module wdog_guarded_bench;

    localparam int BASE = 4;
    localparam int NV   = 9;

    // {config byte, expected kind (0 none, 1 irq, 2 reset), expected cycles}
    localparam logic [31:0] VEC [NV] = '{
        {8'h18, 2'd2, 22'd4},     // reset only, p=0
        {8'h50, 2'd1, 22'd4},     // irq only, p=0
        {8'h52, 2'd1, 22'd16},    // irq only, p=2
        {8'h1D, 2'd2, 22'd128},   // reset only, p=5
        {8'h39, 2'd2, 22'd2048},  // reset only, p=9
        {8'h3F, 2'd2, 22'd2048},  // p=15 clamps to 9
        {8'h10, 2'd0, 22'd0},     // stopped
        {8'h58, 2'd1, 22'd4},     // dual, first event is irq
        {8'h73, 2'd1, 22'd2048}   // irq only, p=11 clamps to 9
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       wdt_flag_in = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       sys_rst_req;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    wdog_guarded #(
        .BASE_CYCLES (BASE),
        .PRESC_CAP   (9),
        .GUARD_CYCLES(4)
    ) u_wdog_guarded (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .kick       (kick),
        .wdt_flag_in(wdt_flag_in),
        .irq_ack    (irq_ack),
        .irq        (irq),
        .sys_rst_req(sys_rst_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; kick = 1'b0; irq_ack = 1'b0; wdt_flag_in = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    // waits for an event; kind 1 = irq, 2 = reset request
    task automatic wait_event(input int lim, input bit rst_only, output int n, output int kind);
        n = 0; kind = 0;
        while (n < lim) begin
            tick();
            n++;
            if (sys_rst_req) begin kind = 2; break; end
            if (!rst_only && irq) begin kind = 1; break; end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n, k;
        #1;
        do_reset();

        // R1: reset state
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(sys_rst_req == 1'b0, "R1 sys_rst_req", sys_rst_req, 0);

        // vector table: R2 stopped, R3 period and clamp, R4 irq mode, R5 reset mode
        for (int i = 0; i < NV; i++) begin
            int ek, ec;
            ek = int'(VEC[i][23:22]);
            ec = int'(VEC[i][21:0]);
            do_reset();
            wr(VEC[i][31:24]);
            wait_event((ek == 0) ? 64 : ec + 4, 1'b0, n, k);
            if (ek == 0) check(k == 0, "R2 stopped no event", k, 0);
            else if (ek == 1) check(k == 1, "R4 irq mode event", k, 1);
            else check(k == 2, "R5 reset mode event", k, 2);
            if (ek != 0) check(n == ec, "R3 timeout cycles", n, ec);
            if (ek == 1) check(rd_data[7] == 1'b1, "R4 flag bit", rd_data[7], 1);
        end

        // R6: dual mode with acknowledge
        do_reset();
        wr(8'h58);
        wait_event(10, 1'b0, n, k);
        check(k == 1 && n == 4, "R6 first timeout irq", n, 4);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        check(rd_data == 8'h08, "R6 ack leaves reset-only", rd_data, 8'h08);
        check(irq == 1'b0, "R6 irq dropped", irq, 0);
        wait_event(10, 1'b1, n, k);
        check(k == 2 && n == 3, "R6 reset after ack", n, 3);
        tick();
        check(sys_rst_req == 1'b0, "R5 pulse width", sys_rst_req, 0);

        // R6: dual mode without acknowledge
        do_reset();
        wr(8'h58);
        wait_event(10, 1'b0, n, k);
        check(k == 1 && n == 4, "R6 first irq", n, 4);
        wait_event(10, 1'b1, n, k);
        check(k == 2 && n == 4, "R6 reset without ack", n, 4);

        // R1: reset mid-run clears everything
        do_reset();
        check(rd_data == 8'h00 && !irq && !sys_rst_req, "R1 reset mid-run", rd_data, 0);

        // R7: flag clearing
        wr(8'h50);
        wait_event(10, 1'b0, n, k);
        check(k == 1, "R7 irq raised", k, 1);
        wr(8'h40);
        check(rd_data[7] == 1'b1 && irq, "R7 write zero keeps flag", rd_data[7], 1);
        wr(8'hC0);
        check(rd_data == 8'h40 && !irq, "R7 write one clears flag", rd_data, 8'h40);
        wait_event(10, 1'b0, n, k);
        check(k == 1 && n == 4, "R7 irq again", n, 4);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        check(rd_data == 8'h40 && !irq, "R7 ack keeps ie", rd_data, 8'h40);

        // R8: change guard
        do_reset();
        wr(8'h1A);
        check(rd_data == 8'h1A, "R8 guarded write", rd_data, 8'h1A);
        for (int i = 0; i < 5; i++) tick();
        check(rd_data == 8'h0A, "R8 after window", rd_data, 8'h0A);
        wr(8'h05);
        check(rd_data == 8'h0A, "R8 unguarded write ignored", rd_data, 8'h0A);
        wr(8'h15);
        check(rd_data == 8'h15, "R8 guarded clear", rd_data, 8'h15);
        wr(8'h08);
        check(rd_data == 8'h0D, "R8 set re without guard", rd_data, 8'h0D);

        // R9: change-enable window length
        do_reset();
        wr(8'h10);
        for (int i = 0; i < 4; i++) begin
            check(rd_data[4] == 1'b1, "R9 window open", rd_data[4], 1);
            tick();
        end
        check(rd_data[4] == 1'b0, "R9 window closed", rd_data[4], 0);

        // R10: external reset flag forces reset enable
        do_reset();
        wdt_flag_in = 1'b1;
        tick();
        check(rd_data[3] == 1'b1, "R10 forced on", rd_data[3], 1);
        wr(8'h10);
        check(rd_data[3] == 1'b1, "R10 clear ignored", rd_data[3], 1);
        wdt_flag_in = 1'b0;
        tick();
        check(rd_data[3] == 1'b1, "R10 stored after release", rd_data[3], 1);

        // R11: kick restarts the count; R5 repetition
        do_reset();
        wr(8'h1A);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (sys_rst_req) k = 1;
        end
        check(k == 0, "R11 no early reset", k, 0);
        kick = 1'b1; tick(); kick = 1'b0;
        wait_event(40, 1'b1, n, k);
        check(k == 2 && n == 16, "R11 timeout after kick", n, 16);
        tick();
        check(sys_rst_req == 1'b0, "R5 single cycle", sys_rst_req, 0);
        wait_event(40, 1'b1, n, k);
        check(k == 2 && n == 15, "R5 repeat period", n, 15);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule